// File: doc/BRIEF.md
# Center-Aligned PWM Compare Unit

This block generates a set of pulse-width-modulated channel outputs from one shared timer. The timer counts either in a triangle (up to a programmable period and back down to zero, for center-aligned PWM) or as a sawtooth (up to the period and then back to zero, for edge-aligned PWM). Each channel compares the timer against its own threshold. A channel output is either at the channel's passive (initial) level or at its inverted, active level. Several rules settle the cases where a threshold hit lands on the same cycle as the timer's zero or period point, so duty cycles of 0 % and 100 % come out cleanly.

Software never changes the live thresholds or passive levels directly. It writes them into shadow registers and then arms a transfer. The transfer copies every shadow register into the live set at the next qualifying timer event, clears the arm flag and pulses a done flag. A fault input is synchronized and latched, and it drives every output to its passive level until software clears it. A disable switch can cancel this forcing.

All inputs and outputs are plain control and status pins with no valid/ready handshake. Shadow writes and arming take effect in the cycle they are presented and cannot be back-pressured.

Top module: `pwm_cmp_unit`

## Requirements
- R1: The timer starts at 0 after reset. In center mode it counts 0,1,…,P,P-1,…,1,0,1,… (one PWM cycle is 2P clocks). In edge mode it counts 0,1,…,P,0,1,… (one cycle is P+1 clocks). P is the `period` input and must be at least 2.
- R2: In center mode, a threshold hit while counting up makes the channel active and a hit while counting down makes it passive. Every zero point returns the channel to passive unless R3 applies. With a threshold c where 0<c<P, a channel is active for 2(P-c) of every 2P clocks.
- R3: A threshold hit in the same cycle as the timer zero point makes the channel active. A threshold of 0 in center mode therefore gives 2P active clocks of 2P.
- R4: A threshold hit in the same cycle as the timer period point makes the channel passive. A threshold equal to P therefore gives 0 active clocks, and so does a threshold above P.
- R5: In edge mode, a threshold hit makes the channel active and the period point makes it passive (R3 and R4 still apply). Threshold c gives P-c active clocks of P+1 for c<P.
- R6: Output bit i equals the channel's passive level when passive and its inverse when active. After reset, the live thresholds are all ones, the passive levels are 0, and all outputs are 0.
- R7: A shadow write (`shw_en`, channel `shw_sel`, value `shw_cmp`, level `shw_lvl`) has no effect on the outputs until an armed transfer occurs. A transfer occurs at the period point in edge mode, and at either the zero or the period point in center mode.
- R8: `xfer_arm` sets an internal flag. The transfer clears that flag, and `xfer_done` is high for exactly one cycle, the cycle after the transfer. One arm gives exactly one done pulse.
- R9: A transferred threshold is first compared in the cycle after the transfer. A threshold of 0 that is transferred at a zero point first takes effect at the following zero point, 2P clocks later.
- R10: A transferred passive level shows on the output in the same cycle that `xfer_done` is high.
- R11: `trap_in` passes through a two-flop synchronizer and sets a trap latch. While the latch is set, every output equals its passive level. `trap_clr` clears the latch only while the synchronized trap input is low.
- R12: With `trap_off` high, a set trap latch does not change the outputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| center_mode | input | 1 | 1 = center-aligned triangle count, 0 = edge-aligned sawtooth |
| period | input | CW | Timer turning point P (at least 2) |
| shw_en | input | 1 | Shadow write strobe |
| shw_sel | input | SELW | Channel index for the shadow write |
| shw_cmp | input | CW | Shadow threshold value |
| shw_lvl | input | 1 | Shadow passive level |
| xfer_arm | input | 1 | Arms a shadow-to-live transfer |
| trap_in | input | 1 | Asynchronous fault input |
| trap_clr | input | 1 | Clears the trap latch when the fault is gone |
| trap_off | input | 1 | Cancels the trap forcing |
| pwm_out | output | NCH | Channel output levels |
| xfer_done | output | 1 | One-cycle pulse after a transfer |

## Verification
The bound checker covers the coincidence rules cycle by cycle. It checks that a zero-point hit yields an active channel, that a period-point hit yields a passive one, and that a center-mode zero point without a hit yields a passive one. It also checks that live values change only alongside a done pulse, that a done pulse follows an armed qualifying event and clears the flag, and that the outputs equal the passive levels whenever the trap forcing applies. The bench scenarios show the effects that build up over many cycles. These are the duty counts per threshold and mode, the PWM cycle length, the fact that an unarmed shadow write changes nothing, the one-event delay of a new threshold against the immediate effect of a new passive level, and the clearing rules of the trap latch.

// File: rtl/pwm_pkg.sv
package pwm_pkg;
  typedef struct packed {
    logic zero;
    logic per;
    logic up;
  } tmr_ev_t;
endpackage

// File: rtl/pwm_timer.sv
module pwm_timer import pwm_pkg::*; #(
  parameter int CW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          center_mode,
  input  logic [CW-1:0] period,
  output logic [CW-1:0] cnt,
  output tmr_ev_t       ev
);
  logic up_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt  <= '0;
      up_q <= 1'b1;
    end else if (center_mode) begin
      if (up_q) begin
        if (cnt >= period) begin
          cnt  <= period - CW'(1);
          up_q <= 1'b0;
        end else begin
          cnt <= cnt + CW'(1);
        end
      end else if (cnt == '0) begin
        cnt  <= CW'(1);
        up_q <= 1'b1;
      end else begin
        cnt <= cnt - CW'(1);
      end
    end else begin
      up_q <= 1'b1;
      cnt  <= (cnt >= period) ? '0 : cnt + CW'(1);
    end
  end

  always_comb begin
    ev.zero = (cnt == '0);
    ev.per  = (cnt == period);
    ev.up   = up_q;
  end
endmodule

// File: rtl/pwm_shadow.sv
module pwm_shadow import pwm_pkg::*; #(
  parameter int NCH  = 3,
  parameter int CW   = 8,
  parameter int SELW = 2
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     center_mode,
  input  tmr_ev_t                  ev,
  input  logic                     shw_en,
  input  logic [SELW-1:0]          shw_sel,
  input  logic [CW-1:0]            shw_cmp,
  input  logic                     shw_lvl,
  input  logic                     xfer_arm,
  output logic [NCH-1:0][CW-1:0]   cmp_act,
  output logic [NCH-1:0]           lvl_act,
  output logic                     pend,
  output logic                     done
);
  logic [NCH-1:0][CW-1:0] cmp_sh;
  logic [NCH-1:0]         lvl_sh;
  logic                   qual, fire;

  assign qual = center_mode ? (ev.zero | ev.per) : ev.per;
  assign fire = pend & qual;

  for (genvar i = 0; i < NCH; i++) begin : g_reg
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        cmp_sh[i]  <= '1;
        lvl_sh[i]  <= 1'b0;
        cmp_act[i] <= '1;
        lvl_act[i] <= 1'b0;
      end else begin
        if (shw_en && (32'(shw_sel) == i)) begin
          cmp_sh[i] <= shw_cmp;
          lvl_sh[i] <= shw_lvl;
        end
        if (fire) begin
          cmp_act[i] <= cmp_sh[i];
          lvl_act[i] <= lvl_sh[i];
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pend <= 1'b0;
      done <= 1'b0;
    end else begin
      pend <= xfer_arm | (pend & ~fire);
      done <= fire;
    end
  end
endmodule

// File: rtl/pwm_chan.sv
module pwm_chan import pwm_pkg::*; #(
  parameter int CW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          center_mode,
  input  logic [CW-1:0] cnt,
  input  tmr_ev_t       ev,
  input  logic [CW-1:0] cmp,
  input  logic          lvl,
  input  logic          force_passive,
  output logic          st,
  output logic          pin
);
  logic hit, st_nx;

  assign hit = (cnt == cmp);

  always_comb begin
    if (hit && ev.zero)                  st_nx = 1'b1;
    else if (hit && ev.per)              st_nx = 1'b0;
    else if (center_mode && ev.zero)     st_nx = 1'b0;
    else if (!center_mode && ev.per)     st_nx = 1'b0;
    else if (hit)                        st_nx = center_mode ? ev.up : 1'b1;
    else                                 st_nx = st;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) st <= 1'b0;
    else        st <= st_nx;
  end

  assign pin = force_passive ? lvl : (st ^ lvl);
endmodule

// File: rtl/pwm_trap.sv
module pwm_trap (
  input  logic clk,
  input  logic rst_n,
  input  logic trap_in,
  input  logic trap_clr,
  output logic trap_lat
);
  logic [1:0] sync_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sync_q   <= '0;
      trap_lat <= 1'b0;
    end else begin
      sync_q <= {sync_q[0], trap_in};
      if (sync_q[1])     trap_lat <= 1'b1;
      else if (trap_clr) trap_lat <= 1'b0;
    end
  end
endmodule

// File: rtl/pwm_cmp_unit.sv
module pwm_cmp_unit import pwm_pkg::*; #(
  parameter int NCH  = 3,
  parameter int CW   = 8,
  localparam int SELW = (NCH > 1) ? $clog2(NCH) : 1
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            center_mode,
  input  logic [CW-1:0]   period,
  input  logic            shw_en,
  input  logic [SELW-1:0] shw_sel,
  input  logic [CW-1:0]   shw_cmp,
  input  logic            shw_lvl,
  input  logic            xfer_arm,
  input  logic            trap_in,
  input  logic            trap_clr,
  input  logic            trap_off,
  output logic [NCH-1:0]  pwm_out,
  output logic            xfer_done
);
  logic [CW-1:0]          cnt;
  tmr_ev_t                ev;
  logic [NCH-1:0][CW-1:0] cmp_act;
  logic [NCH-1:0]         lvl_act;
  logic [NCH-1:0]         st;
  logic                   pend;
  logic                   trap_lat;
  logic                   force_passive;

  assign force_passive = trap_lat & ~trap_off;

  pwm_timer #(.CW(CW)) u_tmr (
    .clk(clk), .rst_n(rst_n), .center_mode(center_mode),
    .period(period), .cnt(cnt), .ev(ev)
  );

  pwm_shadow #(.NCH(NCH), .CW(CW), .SELW(SELW)) u_shd (
    .clk(clk), .rst_n(rst_n), .center_mode(center_mode), .ev(ev),
    .shw_en(shw_en), .shw_sel(shw_sel), .shw_cmp(shw_cmp), .shw_lvl(shw_lvl),
    .xfer_arm(xfer_arm), .cmp_act(cmp_act), .lvl_act(lvl_act),
    .pend(pend), .done(xfer_done)
  );

  pwm_trap u_trp (
    .clk(clk), .rst_n(rst_n), .trap_in(trap_in),
    .trap_clr(trap_clr), .trap_lat(trap_lat)
  );

  for (genvar i = 0; i < NCH; i++) begin : g_ch
    pwm_chan #(.CW(CW)) u_ch (
      .clk(clk), .rst_n(rst_n), .center_mode(center_mode),
      .cnt(cnt), .ev(ev), .cmp(cmp_act[i]), .lvl(lvl_act[i]),
      .force_passive(force_passive), .st(st[i]), .pin(pwm_out[i])
    );
  end
endmodule

// File: rtl/pwm_cmp_unit_chk.sv
module pwm_cmp_unit_chk #(
  parameter int NCH = 3,
  parameter int CW  = 8
) (
  input logic                   clk,
  input logic                   rst_n,
  input logic                   center_mode,
  input logic [CW-1:0]          cnt,
  input logic [CW-1:0]          period,
  input logic [NCH-1:0][CW-1:0] cmp_act,
  input logic [NCH-1:0]         lvl_act,
  input logic [NCH-1:0]         st,
  input logic [NCH-1:0]         pwm_out,
  input logic                   pend,
  input logic                   xfer_arm,
  input logic                   xfer_done,
  input logic                   trap_lat,
  input logic                   trap_off
);
  logic zero_pt, per_pt;
  assign zero_pt = (cnt == '0);
  assign per_pt  = (cnt == period);

  for (genvar i = 0; i < NCH; i++) begin : g_a
    assert_zero_hit_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (zero_pt && cmp_act[i] == cnt) |=> st[i]);
    assert_period_hit_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (per_pt && !zero_pt && cmp_act[i] == cnt) |=> !st[i]);
    assert_zero_return_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (center_mode && zero_pt && cmp_act[i] != cnt) |=> !st[i]);
  end

  assert_live_only_on_xfer_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (cmp_act != $past(cmp_act) || lvl_act != $past(lvl_act)) |-> xfer_done);
  assert_done_after_event_R8: assert property (@(posedge clk) disable iff (!rst_n)
    xfer_done |-> ($past(pend) && ($past(per_pt) || ($past(center_mode) && $past(zero_pt)))));
  assert_flag_clears_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (xfer_done && !$past(xfer_arm)) |-> !pend);
  assert_trap_force_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (trap_lat && !trap_off) |-> (pwm_out == lvl_act));
endmodule

bind pwm_cmp_unit pwm_cmp_unit_chk #(.NCH(NCH), .CW(CW)) chk_i (
  .clk(clk), .rst_n(rst_n), .center_mode(center_mode), .cnt(cnt),
  .period(period), .cmp_act(cmp_act), .lvl_act(lvl_act), .st(st),
  .pwm_out(pwm_out), .pend(pend), .xfer_arm(xfer_arm),
  .xfer_done(xfer_done), .trap_lat(trap_lat), .trap_off(trap_off)
);

// File: tb/pwm_cmp_unit_tb_top.sv
module pwm_cmp_unit_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int NCH = 3;
  localparam int CW  = 8;
  localparam int P   = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic center_mode = 1'b1;
  logic [CW-1:0] period = CW'(P);
  logic shw_en = 1'b0;
  logic [1:0] shw_sel = '0;
  logic [CW-1:0] shw_cmp = '0;
  logic shw_lvl = 1'b0;
  logic xfer_arm = 1'b0;
  logic trap_in = 1'b0;
  logic trap_clr = 1'b0;
  logic trap_off = 1'b0;
  logic [NCH-1:0] pwm_out;
  logic xfer_done;

  int n_chk = 0;
  int n_bad = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  pwm_cmp_unit #(.NCH(NCH), .CW(CW)) dut_i (
    .clk(clk), .rst_n(rst_n), .center_mode(center_mode), .period(period),
    .shw_en(shw_en), .shw_sel(shw_sel), .shw_cmp(shw_cmp), .shw_lvl(shw_lvl),
    .xfer_arm(xfer_arm), .trap_in(trap_in), .trap_clr(trap_clr),
    .trap_off(trap_off), .pwm_out(pwm_out), .xfer_done(xfer_done)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic load(input int ch, input int c, input bit lv);
    @(negedge clk);
    shw_en = 1'b1; shw_sel = 2'(ch); shw_cmp = CW'(c); shw_lvl = lv;
    @(negedge clk);
    shw_en = 1'b0;
  endtask

  task automatic arm_wait(input string req);
    bit got = 1'b0;
    @(negedge clk); xfer_arm = 1'b1;
    @(negedge clk); xfer_arm = 1'b0;
    for (int k = 0; k < 40; k++) begin
      if (xfer_done) begin got = 1'b1; break; end
      @(negedge clk);
    end
    chk(got, req, int'(got), 1);
    cyc(2*P + 2);
  endtask

  task automatic measure(input int ch, input bit lv, input int win, output int n);
    n = 0;
    for (int k = 0; k < win; k++) begin
      @(negedge clk);
      if (pwm_out[ch] != lv) n++;
    end
  endtask

  task automatic wait_rise(input int ch, output int waited);
    bit prev = pwm_out[ch];
    waited = 0;
    for (int k = 0; k < 40; k++) begin
      @(negedge clk);
      waited++;
      if (pwm_out[ch] && !prev) break;
      prev = pwm_out[ch];
    end
  endtask

  task automatic t_reset;
    rst_n = 1'b0;
    cyc(3);
    chk(pwm_out == '0, "R6 reset outputs", int'(pwm_out), 0);
    chk(xfer_done == 1'b0, "R8 reset done", int'(xfer_done), 0);
    @(negedge clk); rst_n = 1'b1;
    cyc(2);
    chk(pwm_out == '0, "R6 idle after reset", int'(pwm_out), 0);
  endtask

  task automatic t_center;
    int n;
    load(0, 1, 1'b0); load(1, 0, 1'b0); load(2, P, 1'b0);
    arm_wait("R7 center transfer");
    measure(0, 1'b0, 2*P, n); chk(n == 2*(P-1), "R2 duty c=1", n, 2*(P-1));
    measure(1, 1'b0, 2*P, n); chk(n == 2*P, "R3 duty c=0", n, 2*P);
    measure(2, 1'b0, 2*P, n); chk(n == 0, "R4 duty c=P", n, 0);
  endtask

  task automatic t_noarm;
    int n;
    load(0, 3, 1'b0);
    cyc(2*P + 2);
    measure(0, 1'b0, 2*P, n); chk(n == 2*(P-1), "R7 unarmed write ignored", n, 2*(P-1));
    arm_wait("R7 armed transfer");
    measure(0, 1'b0, 2*P, n); chk(n == 2*(P-3), "R7 new duty after arm", n, 2*(P-3));
  endtask

  task automatic t_single_done;
    int n = 0;
    @(negedge clk); xfer_arm = 1'b1;
    @(negedge clk); xfer_arm = 1'b0;
    for (int k = 0; k < 30; k++) begin
      if (xfer_done) n++;
      @(negedge clk);
    end
    chk(n == 1, "R8 one done per arm", n, 1);
  endtask

  task automatic t_delay;
    int w, n;
    bit ok;
    load(0, 1, 1'b0); load(1, P + 3, 1'b0);
    arm_wait("R8 prep transfer");
    wait_rise(0, w);
    wait_rise(0, w);
    chk(w == 2*P, "R1 center cycle length", w, 2*P);
    load(1, 0, 1'b1);
    wait_rise(0, w);
    cyc(2);
    xfer_arm = 1'b1;
    @(negedge clk); xfer_arm = 1'b0;
    for (int k = 0; k < 20; k++) begin
      if (xfer_done) break;
      @(negedge clk);
    end
    chk(xfer_done == 1'b1, "R8 done at zero transfer", int'(xfer_done), 1);
    chk(pwm_out[1] == 1'b1, "R10 new passive level immediate", int'(pwm_out[1]), 1);
    ok = 1'b1;
    for (int k = 1; k < 2*P; k++) begin
      @(negedge clk);
      if (pwm_out[1] != 1'b1) ok = 1'b0;
    end
    chk(ok, "R9 zero threshold waits for next zero", int'(ok), 1);
    @(negedge clk);
    chk(pwm_out[1] == 1'b0, "R9 active at following zero", int'(pwm_out[1]), 0);
    n = 0;
    for (int k = 0; k < 24; k++) begin
      if (xfer_done) n++;
      @(negedge clk);
    end
    chk(n == 0, "R8 flag cleared no further done", n, 0);
  endtask

  task automatic t_trap;
    int n;
    measure(1, 1'b1, 2*P, n); chk(n == 2*P, "R6 inverted level active", n, 2*P);
    trap_in = 1'b1;
    cyc(5);
    measure(0, 1'b0, 2*P, n); chk(n == 0, "R11 trap forces ch0", n, 0);
    measure(1, 1'b1, 2*P, n); chk(n == 0, "R11 trap forces ch1", n, 0);
    trap_clr = 1'b1; @(negedge clk); trap_clr = 1'b0;
    trap_in = 1'b0;
    cyc(5);
    measure(0, 1'b0, 2*P, n); chk(n == 0, "R11 latch holds", n, 0);
    trap_clr = 1'b1; @(negedge clk); trap_clr = 1'b0;
    cyc(2);
    measure(0, 1'b0, 2*P, n); chk(n == 2*(P-1), "R11 cleared resumes", n, 2*(P-1));
    trap_off = 1'b1; trap_in = 1'b1;
    cyc(5);
    measure(0, 1'b0, 2*P, n); chk(n == 2*(P-1), "R12 trap disabled", n, 2*(P-1));
    trap_in = 1'b0;
    cyc(4);
    trap_clr = 1'b1; @(negedge clk); trap_clr = 1'b0;
    trap_off = 1'b0;
    cyc(2);
    measure(0, 1'b0, 2*P, n); chk(n == 2*(P-1), "R12 clean after clear", n, 2*(P-1));
  endtask

  task automatic t_edge;
    int n, w;
    center_mode = 1'b0;
    load(0, 1, 1'b0); load(1, 0, 1'b0); load(2, P, 1'b0);
    arm_wait("R7 edge transfer");
    measure(0, 1'b0, P+1, n); chk(n == P-1, "R5 edge duty c=1", n, P-1);
    measure(1, 1'b0, P+1, n); chk(n == P, "R5 edge duty c=0", n, P);
    measure(2, 1'b0, P+1, n); chk(n == 0, "R4 edge duty c=P", n, 0);
    wait_rise(0, w);
    wait_rise(0, w);
    chk(w == P+1, "R1 edge cycle length", w, P+1);
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    n_bad++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end

  initial begin
    t_reset();
    t_center();
    t_noarm();
    t_single_done();
    t_delay();
    t_trap();
    t_edge();
    $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end
endmodule